// File: doc/BRIEF.md
# GMSK Pulse-Shaping Sample Generator

This block turns a serial transmit bit stream into a stream of 8-bit sample codes that trace a Gaussian-filtered pulse with a bandwidth-time product of 0.5. The codes drive an external voltage-output DAC, whose output modulates a VCO. The sample rate is a fixed multiple of the bit rate. Two select pins choose a system clock of 9, 12 or 16 times the bit rate. For the two faster clocks an internal divide-by-two stage lowers the table rate to 6 or 8 samples per bit. At 9x the divider is bypassed and the table runs at 9 samples per bit.

While the power-down input is high the block holds still. Its three-bit history of data bits is preset from the data level: a low level gives the pattern 010 and a high level gives 101. This lets the same block start cleanly on either side of a link. After power-down is released, the block waits for the first data transition of either polarity. That transition aligns an internal phase counter, so each bit is sampled near the middle of its period. Each sample code is looked up from the bit history and the sample phase. The code is registered together with a one-cycle valid strobe.

Top module: `gmsk_shaper`

## Requirements
- R1: `osr_sel` picks the rate. 2'b00 and 2'b11 give 9 system clocks per bit, with one sample per clock. 2'b01 gives 12 clocks per bit and 6 samples per bit. 2'b10 gives 16 clocks per bit and 8 samples per bit. In the 12x and 16x modes a valid strobe is never followed by another valid strobe in the next cycle.
- R2: While `pwr_dn` is high, `dac_valid` stays low. The history is preset to 3'b010 if `tx_bit` is low and to 3'b101 if it is high. From the next cycle on, `dac_code` shows the code of that preset history at phase 0.
- R3: After `pwr_dn` falls, no sample is produced and `dac_code` holds its value until `tx_bit` changes level. Either a rising or a falling change starts the block.
- R4: Let the change of R3 be registered at clock edge E, and let N be the samples per bit. Sample k (k = 0, 1, ...) appears at edge E+1+k in 9x mode and at edge E+2+2k in the other modes. The sample count is c = k mod N. When c equals N/2 rounded down (4, 3 or 4), `tx_bit` is shifted into the newest history position (bit 0), and that sample already uses the shifted history.
- R5: The sample phase is p = (c - floor(N/2)) mod N. With history h, s(x) = +1 when bit x is 1 and -1 when it is 0. The tail coefficient T is {24,12,5,2,0,0} for N=6, {26,17,10,5,2,1,0,0} for N=8 and {27,19,12,7,4,2,1,0,0} for N=9. The code is 128 + s(h[1])*(112 - T[p] - T[N-1-p]) + s(h[2])*T[p] + s(h[0])*T[N-1-p].
- R6: Once out of reset, `dac_code` changes only on a cycle with `dac_valid` high or on the cycle after `pwr_dn` was high.
- R7: Every valid code lies in 16..240. The codes for histories 010 and 101 at the same phase sum to 256.
- R8: Synchronous active-high `rst` clears `dac_valid`, loads history 010, leaves the block waiting for a data change as in R3, and sets `dac_code` to the phase-0 code of 010 for the selected rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (9x, 12x or 16x the bit rate) |
| rst | input | 1 | Synchronous active-high reset |
| osr_sel | input | 2 | Oversampling ratio select (R1 encoding) |
| tx_bit | input | 1 | Serial transmit data |
| pwr_dn | input | 1 | Power-down; presets history and idles the block |
| dac_code | output | 8 | Registered unsigned sample code, centred on 128 |
| dac_valid | output | 1 | One-cycle strobe marking a new sample code |

## Verification
Bursts are sent in every select encoding, including the 2'b11 alias. Alternating bits exercise the 010 and 101 histories, which are the codes most sensitive to a wrong phase offset. Long runs of equal bits expose errors in the centre coefficient. Mixed patterns exercise all eight histories, so a swapped history bit order shows up. Both presets are used and the first data change is tried in both polarities. This separates the preset logic and the edge detection from the shifting path. The idle gap between power-down release and the first change shows whether any sample leaks out before alignment.

// File: rtl/gmsk_pkg.sv
package gmsk_pkg;

    localparam int CODE_W = 8;
    localparam int PH_W   = 4;
    localparam int HIST_W = 3;
    localparam int MID    = 128;
    localparam int PEAK   = 112;

    typedef enum logic [1:0] {
        OSR_X9  = 2'b00,
        OSR_X12 = 2'b01,
        OSR_X16 = 2'b10,
        OSR_X9B = 2'b11
    } osr_sel_e;

    typedef struct packed {
        logic            halve;
        logic [PH_W-1:0] n;
        logic [PH_W-1:0] half;
    } osr_cfg_t;

    typedef struct packed {
        logic [HIST_W-1:0] hist;
        logic [PH_W-1:0]   phase;
    } sample_addr_t;

    function automatic osr_cfg_t decode_osr(logic [1:0] sel);
        osr_cfg_t c;
        case (osr_sel_e'(sel))
            OSR_X12: begin c.halve = 1'b1; c.n = 4'd6; c.half = 4'd3; end
            OSR_X16: begin c.halve = 1'b1; c.n = 4'd8; c.half = 4'd4; end
            default: begin c.halve = 1'b0; c.n = 4'd9; c.half = 4'd4; end
        endcase
        return c;
    endfunction

    function automatic logic [HIST_W-1:0] preset_hist(logic level);
        return level ? 3'b101 : 3'b010;
    endfunction

    // Decaying tail of a neighbouring bit's pulse, one table per rate.
    function automatic logic [7:0] tail_coef(logic [PH_W-1:0] n, logic [PH_W-1:0] idx);
        logic [7:0] v;
        v = 8'd0;
        case (n)
            4'd6: case (idx)
                4'd0: v = 8'd24;
                4'd1: v = 8'd12;
                4'd2: v = 8'd5;
                4'd3: v = 8'd2;
                default: v = 8'd0;
            endcase
            4'd8: case (idx)
                4'd0: v = 8'd26;
                4'd1: v = 8'd17;
                4'd2: v = 8'd10;
                4'd3: v = 8'd5;
                4'd4: v = 8'd2;
                4'd5: v = 8'd1;
                default: v = 8'd0;
            endcase
            default: case (idx)
                4'd0: v = 8'd27;
                4'd1: v = 8'd19;
                4'd2: v = 8'd12;
                4'd3: v = 8'd7;
                4'd4: v = 8'd4;
                4'd5: v = 8'd2;
                4'd6: v = 8'd1;
                default: v = 8'd0;
            endcase
        endcase
        return v;
    endfunction

    // Superpose the centre pulse and the two neighbour tails.
    function automatic logic [CODE_W-1:0] shape_code(sample_addr_t a, logic [PH_W-1:0] n);
        int t_old;
        int t_new;
        int ctr;
        int acc;
        t_old = int'(tail_coef(n, a.phase));
        t_new = int'(tail_coef(n, n - 4'd1 - a.phase));
        ctr   = PEAK - t_old - t_new;
        acc   = MID;
        acc   = a.hist[1] ? acc + ctr   : acc - ctr;
        acc   = a.hist[2] ? acc + t_old : acc - t_old;
        acc   = a.hist[0] ? acc + t_new : acc - t_new;
        return acc[CODE_W-1:0];
    endfunction

endpackage

// File: rtl/gmsk_tick_gen.sv
module gmsk_tick_gen
    import gmsk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic halve,
    output logic tick
);
    logic div_q;

    always_ff @(posedge clk) begin
        if (rst || !run) div_q <= 1'b0;
        else             div_q <= ~div_q;
    end

    assign tick = run & (halve ? div_q : 1'b1);
endmodule

// File: rtl/gmsk_phase_track.sv
module gmsk_phase_track
    import gmsk_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         pwr_dn,
    input  logic         tx_bit,
    input  logic         tick,
    input  osr_cfg_t     cfg,
    output logic         run,
    output sample_addr_t addr
);
    logic              prev_q;
    logic              run_q;
    logic [PH_W-1:0]   cnt_q;
    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_nxt;
    logic              data_edge;

    assign data_edge = tx_bit ^ prev_q;
    assign hist_nxt  = (cnt_q == cfg.half) ? {hist_q[HIST_W-2:0], tx_bit} : hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            run_q  <= 1'b0;
            cnt_q  <= '0;
            hist_q <= preset_hist(1'b0);
        end else begin
            prev_q <= tx_bit;
            if (pwr_dn) begin
                run_q  <= 1'b0;
                cnt_q  <= '0;
                hist_q <= preset_hist(tx_bit);
            end else if (!run_q) begin
                if (data_edge) begin
                    run_q <= 1'b1;
                    cnt_q <= '0;
                end
            end else if (tick) begin
                cnt_q  <= (cnt_q == cfg.n - 4'd1) ? '0 : cnt_q + 4'd1;
                hist_q <= hist_nxt;
            end
        end
    end

    assign run        = run_q;
    assign addr.hist  = hist_nxt;
    assign addr.phase = (cnt_q >= cfg.half) ? cnt_q - cfg.half
                                            : cnt_q + (cfg.n - cfg.half);
endmodule

// File: rtl/gmsk_code_reg.sv
module gmsk_code_reg
    import gmsk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_dn,
    input  logic              tx_bit,
    input  logic              tick,
    input  osr_cfg_t          cfg,
    input  sample_addr_t      addr,
    output logic [CODE_W-1:0] code,
    output logic              valid
);
    sample_addr_t idle_addr;
    sample_addr_t rst_addr;

    assign idle_addr.hist  = preset_hist(tx_bit);
    assign idle_addr.phase = '0;
    assign rst_addr.hist   = preset_hist(1'b0);
    assign rst_addr.phase  = '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            code  <= shape_code(rst_addr, cfg.n);
            valid <= 1'b0;
        end else if (pwr_dn) begin
            code  <= shape_code(idle_addr, cfg.n);
            valid <= 1'b0;
        end else begin
            valid <= tick;
            if (tick) code <= shape_code(addr, cfg.n);
        end
    end
endmodule

// File: rtl/gmsk_shaper.sv
module gmsk_shaper
    import gmsk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        osr_sel,
    input  logic              tx_bit,
    input  logic              pwr_dn,
    output logic [CODE_W-1:0] dac_code,
    output logic              dac_valid
);
    osr_cfg_t     cfg;
    sample_addr_t addr;
    logic         run;
    logic         tick;

    assign cfg = decode_osr(osr_sel);

    gmsk_tick_gen u_tick (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .halve (cfg.halve),
        .tick  (tick)
    );

    gmsk_phase_track u_phase (
        .clk    (clk),
        .rst    (rst),
        .pwr_dn (pwr_dn),
        .tx_bit (tx_bit),
        .tick   (tick),
        .cfg    (cfg),
        .run    (run),
        .addr   (addr)
    );

    gmsk_code_reg u_code (
        .clk    (clk),
        .rst    (rst),
        .pwr_dn (pwr_dn),
        .tx_bit (tx_bit),
        .tick   (tick),
        .cfg    (cfg),
        .addr   (addr),
        .code   (dac_code),
        .valid  (dac_valid)
    );
endmodule

// File: rtl/gmsk_shaper_chk.sv
module gmsk_shaper_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] osr_sel,
    input logic       pwr_dn,
    input logic [7:0] dac_code,
    input logic       dac_valid
);
    assert_pd_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        pwr_dn |=> !dac_valid);

    assert_halved_rate_R1: assert property (@(posedge clk) disable iff (rst)
        (dac_valid && (osr_sel == 2'b01 || osr_sel == 2'b10)) |=> !dac_valid);

    assert_full_rate_R1: assert property (@(posedge clk) disable iff (rst)
        (dac_valid && !pwr_dn && (osr_sel == 2'b00 || osr_sel == 2'b11)) |=> dac_valid);

    assert_code_range_R7: assert property (@(posedge clk) disable iff (rst)
        dac_valid |-> (dac_code >= 8'd16 && dac_code <= 8'd240));

    assert_code_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!dac_valid && !$past(pwr_dn) && !$past(rst)) |-> $stable(dac_code));
endmodule

bind gmsk_shaper gmsk_shaper_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .osr_sel   (osr_sel),
    .pwr_dn    (pwr_dn),
    .dac_code  (dac_code),
    .dac_valid (dac_valid)
);

// File: tb/sim_gmsk_shaper.sv
module sim_gmsk_shaper;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] osr_sel = 2'b00;
    logic       tx_bit = 1'b0;
    logic       pwr_dn = 1'b0;
    logic [7:0] dac_code;
    logic       dac_valid;

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_q[$];
    string      cur_tag = "R5";

    always #4 clk = ~clk;

    gmsk_shaper u0 (
        .clk(clk), .rst(rst), .osr_sel(osr_sel), .tx_bit(tx_bit),
        .pwr_dn(pwr_dn), .dac_code(dac_code), .dac_valid(dac_valid)
    );

    function automatic int ref_tail(int n, int i);
        int t6[6] = '{24, 12, 5, 2, 0, 0};
        int t8[8] = '{26, 17, 10, 5, 2, 1, 0, 0};
        int t9[9] = '{27, 19, 12, 7, 4, 2, 1, 0, 0};
        if (n == 6) return t6[i];
        if (n == 8) return t8[i];
        return t9[i];
    endfunction

    function automatic logic [7:0] ref_code(logic [2:0] h, int p, int n);
        int to = ref_tail(n, p);
        int tn = ref_tail(n, n - 1 - p);
        int v = 128;
        v += (h[1] ? 1 : -1) * (112 - to - tn);
        v += (h[2] ? 1 : -1) * to;
        v += (h[0] ? 1 : -1) * tn;
        return v[7:0];
    endfunction

    function automatic int spb(logic [1:0] s);
        return (s == 2'b01) ? 6 : (s == 2'b10) ? 8 : 9;
    endfunction

    function automatic int cpb(logic [1:0] s);
        return (s == 2'b01) ? 12 : (s == 2'b10) ? 16 : 9;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pop and compare each valid sample.
    always @(negedge clk) begin
        if (!rst && dac_valid && exp_q.size() > 0) begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(cur_tag, dac_code, e);
            checks++;
            if (dac_code < 8'd16 || dac_code > 8'd240) begin
                errors++;
                $display("FAIL R7: actual=%0d expected=16..240", dac_code);
            end
        end
    end

    // Driver: one burst in mode sel, preset from level pre, m bits from word.
    task automatic burst(logic [1:0] sel, logic pre, logic [63:0] word, int m, string tag);
        int n = spb(sel);
        int half = n / 2;
        logic [2:0] h;
        logic [7:0] held;
        int bad;
        @(negedge clk);
        pwr_dn = 1'b1; osr_sel = sel; tx_bit = pre;
        repeat (4) @(negedge clk);
        h = pre ? 3'b101 : 3'b010;
        check("R2 preset code", dac_code, ref_code(h, 0, n));
        check("R2 valid low", {7'd0, dac_valid}, 8'd0);
        pwr_dn = 1'b0;
        held = dac_code;
        bad = 0;
        repeat (8) begin
            @(negedge clk);
            if (dac_valid || dac_code !== held) bad++;
        end
        check("R3 idle before edge", bad[7:0], 8'd0);
        for (int k = 0; k < m * n; k++) begin
            int c = k % n;
            int p = (c - half + n) % n;
            if (c == half) h = {h[1:0], word[k / n]};
            exp_q.push_back(ref_code(h, p, n));
        end
        cur_tag = tag;
        for (int i = 0; i < m; i++) begin
            tx_bit = word[i];
            repeat (cpb(sel)) @(negedge clk);
        end
        while (exp_q.size() > 0) @(negedge clk);
        pwr_dn = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 valid low after burst", {7'd0, dac_valid}, 8'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 reset code", dac_code, ref_code(3'b010, 0, 9));
        check("R8 reset valid", {7'd0, dac_valid}, 8'd0);
        // R1 R4 R5: alternating bits at 9x, low preset, rising first change
        burst(2'b00, 1'b0, 64'h5555, 14, "R5 x9 alternating");
        // R1 R4 R5: mixed bits at 12x, high preset, falling first change
        burst(2'b01, 1'b1, 64'hB2C6, 16, "R5 x12 mixed");
        // R1 R4 R5: long runs at 16x
        burst(2'b10, 1'b0, 64'h0F0F3, 20, "R5 x16 runs");
        // R1: alias encoding 2'b11 behaves as 9x
        burst(2'b11, 1'b1, 64'h36A4, 16, "R1 alias x9");
        // R7: symmetric preset codes
        check("R7 symmetry x16", ref_code(3'b010, 0, 8) + ref_code(3'b101, 0, 8), 8'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule